// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block raises interrupts for four message mailboxes: two inboxes and two outboxes. Three agents share them: a host bus agent and two processor agents. Each agent owns one enable bit and one pending bit per mailbox. A mailbox event arrives as a one-cycle strobe. It latches the matching pending bit only while the matching enable bit is set. Software clears a pending bit by writing a 1 to it.

Each agent gets a single registered, active-high interrupt line. That line is the OR of the agent's four pending bits. The second processor agent's outbox pending bits have one more source: the host writes an acknowledge word after it has read an outbox, and this sets those bits.

All registers sit behind a plain single-cycle write port with a combinational read port. The mailbox data registers and the host bus protocol lie outside this block.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset, every enable bit, every pending bit and every interrupt output is 0.
- R2: The enable register (address 0) holds 12 writable bits in three groups of four. Bits 0-3 belong to the host, bits 4-7 to processor 1 and bits 8-11 to processor 2. Within each group the order is inbox 0, inbox 1, outbox 0, outbox 1. A write reads back unchanged.
- R3: Bits 15:12 of the enable register and of the status register (address 1) always read 0, and writes to them are ignored.
- R4: When event strobe `evt_i[k]` is high while enable bit k is 1, status bit k reads 1 from the next cycle onward.
- R5: An event, or an acknowledge, whose enable bit is 0 leaves the status bit at 0 and raises no interrupt.
- R6: A write to the status register clears each bit written as 1. Bits written as 0 keep their value.
- R7: A write to the acknowledge register (address 2) with bit 14 set sets status bit 10 (processor 2, outbox 0) when enable bit 10 is 1. Bit 15 does the same for status bit 11. The other bits of the word have no effect, and the register reads as 0.
- R8: When a set event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq_o[a]` is the OR of status bits 4a to 4a+3, delayed by one clock register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 12 | One-cycle mailbox event strobes, one per agent and mailbox, in the status bit order |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 enable, 1 status, 2 acknowledge |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data of the selected register |
| irq_o | output | 3 | Interrupt per agent: bit 0 host, bit 1 processor 1, bit 2 processor 2 |

## Verification
The bench builds the block with its defaults: three agents, two inboxes and two outboxes, a 16-bit register word, and the acknowledge bits at positions 14 and 15 steering processor 2. These values put a reserved nibble in the register word. They also place the acknowledge field outside the used bits, so the reserved read-back and the ignored acknowledge bits can be observed. A table of vectors walks events, clears and acknowledges across all three agents. Directed cases then cover reset, set against clear in the same cycle, and the one-cycle interrupt delay.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

   // Register select codes on the access port
   typedef enum logic [1:0] {
      RA_ENABLE = 2'd0,
      RA_STATUS = 2'd1,
      RA_ACK    = 2'd2,
      RA_NONE   = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/mbx_enable_reg.sv
module mbx_enable_reg #(
   parameter int USED_W = 12,
   parameter int REG_W  = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [REG_W-1:0]  wdata_i,
   output logic [USED_W-1:0] en_o
);

   logic [USED_W-1:0] en_q;

   // Only the implemented bits are stored; the rest of the word is dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (wr_i)
         en_q <= wdata_i[USED_W-1:0];
   end

   assign en_o = en_q;

   generate
      if (USED_W < REG_W) begin : g_spare
         logic spare_unused;
         assign spare_unused = ^wdata_i[REG_W-1:USED_W];
      end
   endgenerate

endmodule

// File: rtl/mbx_pending_bank.sv
module mbx_pending_bank #(
   parameter int BOXES = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BOXES-1:0] set_i,
   input  logic [BOXES-1:0] clr_i,
   output logic [BOXES-1:0] pend_o
);

   logic [BOXES-1:0] pend_q;
   logic [BOXES-1:0] pend_d;

   // A set overrides a clear of the same bit, so no event is lost
   always_comb begin
      pend_d = (pend_q & ~clr_i) | set_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else
         pend_q <= pend_d;
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/mbx_irq_combine.sv
module mbx_irq_combine #(
   parameter int NUM_AGENTS = 3,
   parameter int BOXES      = 4,
   parameter bit REGISTERED = 1'b1
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_AGENTS*BOXES-1:0] pend_i,
   output logic [NUM_AGENTS-1:0]       irq_o
);

   logic [NUM_AGENTS-1:0] any_pend;

   generate
      for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_agent
         assign any_pend[a] = |pend_i[a*BOXES +: BOXES];
      end

      if (REGISTERED) begin : g_reg
         logic [NUM_AGENTS-1:0] irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq_q <= '0;
            else
               irq_q <= any_pend;
         end
         assign irq_o = irq_q;
      end else begin : g_comb
         logic clk_unused;
         assign clk_unused = clk ^ rst_n;
         assign irq_o = any_pend;
      end
   endgenerate

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
   import mbx_irq_pkg::*;
#(
   parameter int NUM_AGENTS = 3,
   parameter int INBOXES    = 2,
   parameter int OUTBOXES   = 2,
   parameter int REG_W      = 16,
   parameter int ACK_AGENT  = 2,
   parameter int ACK_BIT0   = 14,
   parameter bit IRQ_REG    = 1'b1
)(
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic [NUM_AGENTS*(INBOXES+OUTBOXES)-1:0]     evt_i,
   input  logic                                         reg_wr_i,
   input  logic [1:0]                                   reg_addr_i,
   input  logic [REG_W-1:0]                             reg_wdata_i,
   output logic [REG_W-1:0]                             reg_rdata_o,
   output logic [NUM_AGENTS-1:0]                        irq_o
);

   localparam int BOXES   = INBOXES + OUTBOXES;
   localparam int USED_W  = NUM_AGENTS * BOXES;
   localparam int ACK_LSB = ACK_AGENT * BOXES + INBOXES;

   // Elaboration-time parameter checks
   generate
      if (USED_W > REG_W) begin : g_chk_width
         $error("mbx_irq_ctrl: enable/status bits exceed register width");
      end
      if (ACK_AGENT >= NUM_AGENTS) begin : g_chk_agent
         $error("mbx_irq_ctrl: acknowledge agent out of range");
      end
      if (ACK_BIT0 + OUTBOXES > REG_W) begin : g_chk_ack
         $error("mbx_irq_ctrl: acknowledge field exceeds register width");
      end
      if (INBOXES < 1 || OUTBOXES < 1) begin : g_chk_boxes
         $error("mbx_irq_ctrl: need at least one inbox and one outbox");
      end
   endgenerate

   reg_sel_e sel;
   logic     wr_enable;
   logic     wr_status;
   logic     wr_ack;

   assign sel       = reg_sel_e'(reg_addr_i);
   assign wr_enable = reg_wr_i && (sel == RA_ENABLE);
   assign wr_status = reg_wr_i && (sel == RA_STATUS);
   assign wr_ack    = reg_wr_i && (sel == RA_ACK);

   logic [USED_W-1:0] en_q;
   logic [USED_W-1:0] pend_q;
   logic [USED_W-1:0] ack_v;
   logic [USED_W-1:0] set_v;
   logic [USED_W-1:0] clr_v;

   // Enable register
   mbx_enable_reg #(
      .USED_W (USED_W),
      .REG_W  (REG_W)
   ) u_enable (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_enable),
      .wdata_i (reg_wdata_i),
      .en_o    (en_q)
   );

   // Acknowledge word: one bit per outbox of the acknowledged agent
   always_comb begin
      ack_v = '0;
      for (int o = 0; o < OUTBOXES; o++) begin
         ack_v[ACK_LSB + o] = wr_ack & reg_wdata_i[ACK_BIT0 + o];
      end
   end

   // Events are gated by the enable bits held before this edge
   assign set_v = (evt_i | ack_v) & en_q;
   assign clr_v = wr_status ? reg_wdata_i[USED_W-1:0] : '0;

   // One pending bank per agent
   generate
      for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_bank
         mbx_pending_bank #(
            .BOXES (BOXES)
         ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[a*BOXES +: BOXES]),
            .clr_i  (clr_v[a*BOXES +: BOXES]),
            .pend_o (pend_q[a*BOXES +: BOXES])
         );
      end
   endgenerate

   // Per-agent interrupt lines
   mbx_irq_combine #(
      .NUM_AGENTS (NUM_AGENTS),
      .BOXES      (BOXES),
      .REGISTERED (IRQ_REG)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend_q),
      .irq_o  (irq_o)
   );

   // Read mux; unimplemented bits read as zero
   always_comb begin
      reg_rdata_o = '0;
      unique case (sel)
         RA_ENABLE: reg_rdata_o = REG_W'(en_q);
         RA_STATUS: reg_rdata_o = REG_W'(pend_q);
         default:   reg_rdata_o = '0;
      endcase
   end

   logic wdata_unused;
   assign wdata_unused = ^reg_wdata_i;

endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk #(
   parameter int NUM_AGENTS = 3,
   parameter int BOXES      = 4,
   parameter int REG_W      = 16,
   parameter int ACK_LSB    = 10,
   parameter int ACK_BIT0   = 14
)(
   input logic                        clk,
   input logic                        rst_n,
   input logic                        reg_wr_i,
   input logic [1:0]                  reg_addr_i,
   input logic [REG_W-1:0]            reg_wdata_i,
   input logic [REG_W-1:0]            reg_rdata_o,
   input logic [NUM_AGENTS-1:0]       irq_o,
   input logic [NUM_AGENTS*BOXES-1:0] en_q,
   input logic [NUM_AGENTS*BOXES-1:0] pend_q,
   input logic [NUM_AGENTS*BOXES-1:0] set_v,
   input logic [NUM_AGENTS*BOXES-1:0] clr_v
);

   localparam int USED_W = NUM_AGENTS * BOXES;

   for (genvar k = 0; k < USED_W; k++) begin : g_bit
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_v[k] |=> pend_q[k]); // R8
      AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_q[k]) |-> $past(en_q[k])); // R5
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_v[k] && !set_v[k]) |=> !pend_q[k]); // R6
      AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_v[k] && !set_v[k]) |=> $stable(pend_q[k])); // R6
   end

   for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_agent
      AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[a] == $past(|pend_q[a*BOXES +: BOXES])); // R9
   end

   if (USED_W < REG_W) begin : g_rsvd
      AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_addr_i == 2'd0 || reg_addr_i == 2'd1) |-> (reg_rdata_o[REG_W-1:USED_W] == '0)); // R3
   end

   AST_ACK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == 2'd2 && reg_wdata_i[ACK_BIT0] && en_q[ACK_LSB]) |=> pend_q[ACK_LSB]); // R7

endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(
   .NUM_AGENTS (NUM_AGENTS),
   .BOXES      (INBOXES + OUTBOXES),
   .REG_W      (REG_W),
   .ACK_LSB    (ACK_AGENT * (INBOXES + OUTBOXES) + INBOXES),
   .ACK_BIT0   (ACK_BIT0)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr_i    (reg_wr_i),
   .reg_addr_i  (reg_addr_i),
   .reg_wdata_i (reg_wdata_i),
   .reg_rdata_o (reg_rdata_o),
   .irq_o       (irq_o),
   .en_q        (en_q),
   .pend_q      (pend_q),
   .set_v       (set_v),
   .clr_v       (clr_v)
);

// File: tb/tb_mbx_irq_ctrl.sv
module tb_mbx_irq_ctrl;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] evt = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [2:0]  irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_irq_ctrl dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .reg_wr_i    (reg_wr),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .irq_o       (irq)
   );

   // Vector: {wr, addr, wdata, evt, expected status[11:0], expected irq}
   localparam int NV = 12;
   localparam logic [45:0] VEC [NV] = '{
      {1'b1, 2'd0, 16'h0FFF, 12'h000, 12'h000, 3'b000}, // R2 enable all
      {1'b0, 2'd0, 16'h0000, 12'h001, 12'h001, 3'b001}, // R4 host inbox0
      {1'b0, 2'd0, 16'h0000, 12'h020, 12'h021, 3'b011}, // R4 proc1 inbox1
      {1'b1, 2'd1, 16'h0001, 12'h000, 12'h020, 3'b010}, // R6 clear bit0
      {1'b1, 2'd1, 16'h0000, 12'h000, 12'h020, 3'b010}, // R6 write zero
      {1'b1, 2'd2, 16'h4000, 12'h000, 12'h420, 3'b110}, // R7 ack outbox0
      {1'b1, 2'd2, 16'h8000, 12'h000, 12'hC20, 3'b110}, // R7 ack outbox1
      {1'b1, 2'd2, 16'h3FFF, 12'h000, 12'hC20, 3'b110}, // R7 other bits
      {1'b1, 2'd1, 16'hFFFF, 12'h000, 12'h000, 3'b000}, // R6 clear all
      {1'b1, 2'd0, 16'h00F0, 12'h000, 12'h000, 3'b000}, // R2 proc1 only
      {1'b0, 2'd0, 16'h0000, 12'hFFF, 12'h0F0, 3'b010}, // R5 masked
      {1'b1, 2'd1, 16'h00F0, 12'h000, 12'h000, 3'b000}  // R6 clear proc1
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      reg_wr   = 1'b0;
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // Drive one cycle of stimulus, then return inputs to idle
   task automatic step(input logic wr, input logic [1:0] a, input logic [15:0] wd, input logic [11:0] e);
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_wdata = wd; evt = e;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; evt = '0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, d); check("R1 enable after reset", d, 16'h0000);
      rd(2'd1, d); check("R1 status after reset", d, 16'h0000);
      check("R1 irq after reset", {13'd0, irq}, 16'h0000);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][45], VEC[i][44:43], VEC[i][42:27], VEC[i][26:15]);
         @(negedge clk);
         rd(2'd1, d);
         check($sformatf("R4/R5/R6/R7 vector %0d status", i), d, {4'h0, VEC[i][14:3]});
         check($sformatf("R9 vector %0d irq", i), {13'd0, irq}, {13'd0, VEC[i][2:0]});
      end

      // R2 enable readback and R3 reserved bits
      step(1'b1, 2'd0, 16'h0A5A, 12'h000);
      rd(2'd0, d); check("R2 enable readback", d, 16'h0A5A);
      step(1'b1, 2'd0, 16'hFFFF, 12'h000);
      rd(2'd0, d); check("R3 enable reserved bits", d, 16'h0FFF);
      step(1'b1, 2'd1, 16'hF000, 12'h000);
      rd(2'd1, d); check("R3 status reserved bits", d, 16'h0000);
      rd(2'd2, d); check("R7 ack reads zero", d, 16'h0000);

      // R9 latency: status set, irq one cycle later
      @(negedge clk);
      evt = 12'h100;
      @(negedge clk);
      evt = '0;
      rd(2'd1, d); check("R4 status next cycle", d, 16'h0100);
      check("R9 irq not yet", {13'd0, irq}, 16'h0000);
      @(negedge clk);
      check("R9 irq after register", {13'd0, irq}, 16'h0004);

      // R8 set beats clear on the same bit; other bit still clears
      @(negedge clk);
      evt = 12'h008; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0108;
      @(negedge clk);
      evt = '0; reg_wr = 1'b0; reg_wdata = '0;
      rd(2'd1, d); check("R8 set wins over clear", d, 16'h0008);
      step(1'b1, 2'd1, 16'h0FFF, 12'h000);

      // R5 acknowledge with enable clear is dropped
      step(1'b1, 2'd0, 16'h0000, 12'h000);
      step(1'b1, 2'd2, 16'hC000, 12'h000);
      @(negedge clk);
      rd(2'd1, d); check("R5 ack masked status", d, 16'h0000);
      check("R5 ack masked irq", {13'd0, irq}, 16'h0000);

      // R1 reset clears state again
      step(1'b1, 2'd0, 16'h0FFF, 12'h000);
      step(1'b0, 2'd0, 16'h0000, 12'h801);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(2'd0, d); check("R1 enable after second reset", d, 16'h0000);
      rd(2'd1, d); check("R1 status after second reset", d, 16'h0000);
      check("R1 irq after second reset", {13'd0, irq}, 16'h0000);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule